// File: doc/BRIEF.md
# Eight-Channel Timer Register Decoder

This block is the register front end shared by a bank of eight timer channels. It takes single 32-bit word accesses from a simple valid/write/address/data port. Each access goes either to one of four registers inside a channel or to one shared control word. Channel register writes leave as a one-cycle strobe, with a register select and the write data, toward the counting logic, which lies outside this block. Channel register reads are taken from the value bus each channel presents.

The shared control word gives every channel a four-bit field. The block turns changes in that field into per-channel levels and action strobes. The order is fixed: a channel being switched off stops in the same cycle as its other settings change, and a channel being switched on starts one cycle after them. Offsets that decode to nothing, and misaligned addresses, return zero and raise a one-cycle error.

Top module: `tmr_bank_decoder`

## Requirements
- R1: After reset every channel level and strobe output is 0, the control word reads back as 0 and the error output is 0.
- R2: The address space is cut into 16-byte slots, and each channel slot holds four words: select 0 count at +0x0, select 1 reload at +0x4, select 2 first match at +0x8, select 3 second match at +0xC. Slots 0 to 2 are channels 0 to 2, slot 3 is the control slot, and slots 4 to 8 are channels 3 to 7. A write to a channel word gives, one cycle after the access, a one-hot channel strobe for exactly one cycle, together with the word select and the data.
- R3: A read of a channel word returns, one cycle after the access, the 32-bit value that channel presents for the selected word.
- R4: The control word sits at offset 0x30 and reads back exactly the last 32-bit value written to it.
- R5: Channel i owns control bits [4i+3:4i]: bit 4i is run enable, bit 4i+1 is external clock select, bit 4i+2 is overflow interrupt enable and bit 4i+3 is pulse mode. The clock-select, interrupt-enable and pulse levels take their new values one cycle after the control write.
- R6: When a channel's enable bit goes from 1 to 0, its enable output falls and its stop strobe pulses in the first cycle after the write, the same cycle as its other settings change.
- R7: When a channel's enable bit goes from 0 to 1, its other settings change in the first cycle after the write, and its enable output rises and its start strobe pulses one cycle later.
- R8: The configuration strobe of a channel pulses only when its clock-select, interrupt-enable or supported pulse bit changes. Rewriting an unchanged value produces no strobe of any kind.
- R9: Pulse mode exists only on channels 4 to 7. Changing the pulse bit of channels 0 to 3 leaves their pulse output at 0, gives no configuration strobe and raises the error output. The bit is still kept in the control word.
- R10: An access to an undecoded offset (0x34, 0x38, 0x3C, anything past 0x8C) or with a nonzero low address bit produces no channel strobe and no control change. A read of such an offset returns 0. Either kind of access raises the error output one cycle later.
- R11: The error output is high for exactly one cycle per failing access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after a read |
| rsp_err | output | 1 | One-cycle error for a failed access |
| ch_wr_o | output | 8 | One-hot channel register write strobe |
| ch_wr_sel_o | output | 2 | Word select of the channel write |
| ch_wr_data_o | output | 32 | Data of the channel write |
| ch_rdata_i | input | 1024 | Word values of all channels, channel c word w at bits [(4c+w)*32 +: 32] |
| ch_en_o | output | 8 | Run enable level per channel |
| ch_clk_ext_o | output | 8 | External clock select per channel |
| ch_irq_en_o | output | 8 | Overflow interrupt enable per channel |
| ch_pulse_o | output | 8 | Pulse mode level per channel |
| ch_dis_stb_o | output | 8 | Stop strobe per channel |
| ch_ena_stb_o | output | 8 | Start strobe per channel |
| ch_cfg_stb_o | output | 8 | Configuration change strobe per channel |

## Verification
The bench builds the block with its default parameters: eight channels, a 12-bit address, the control slot at slot 3 and pulse mode from channel 4 up. With these values both channel groups on either side of the control slot can be reached, as can the unused words next to the control word, the last channel word at 0x8C and the first slot past it. The pulse boundary can be tested with a low channel whose pulse bit is refused and a high channel whose pulse bit is taken. Directed control writes step through enable rising, enable falling, each together with a configuration change on the same channel, and unchanged rewrites, and sample every cycle of the two-cycle sequence.

// File: rtl/tmr_dec_pkg.sv
`timescale 1ns/1ps
package tmr_dec_pkg;

  // width of one channel's field in the control word
  localparam int CTRL_BITS  = 4;
  // bit order inside a channel field, least significant first
  localparam int CB_RUN     = 0;
  localparam int CB_EXTCLK  = 1;
  localparam int CB_IRQ     = 2;
  localparam int CB_PULSE   = 3;
  // registers inside one channel slot
  localparam int WORDS_PER_CH = 4;

  typedef enum logic [1:0] {
    WSEL_COUNT  = 2'd0,
    WSEL_RELOAD = 2'd1,
    WSEL_MATCHA = 2'd2,
    WSEL_MATCHB = 2'd3
  } chan_word_e;

  // slot number to channel index: slots above the control slot shift down by one
  function automatic int unsigned slot_to_chan(int unsigned slot, int unsigned ctrl_slot);
    return (slot < ctrl_slot) ? slot : slot - 1;
  endfunction

  // flat bit offset of one channel word on the read-back bus
  function automatic int unsigned word_base(int unsigned ch, int unsigned wsel, int unsigned dw);
    return (ch * WORDS_PER_CH + wsel) * dw;
  endfunction

endpackage

// File: rtl/tmr_addr_decode.sv
`timescale 1ns/1ps
module tmr_addr_decode
  import tmr_dec_pkg::*;
#(
  parameter int AW        = 12,
  parameter int NUM_CH    = 8,
  parameter int CTRL_SLOT = 3,
  localparam int CHW      = $clog2(NUM_CH),
  localparam int SW       = AW - 4
) (
  input  logic [AW-1:0]  addr,
  output logic           hit_ch,
  output logic           hit_ctrl,
  output logic           miss,
  output logic [CHW-1:0] ch_idx,
  output chan_word_e     wsel
);

  logic [SW-1:0] slot;
  logic          aligned;

  assign slot    = addr[AW-1:4];
  assign aligned = (addr[1:0] == 2'b00);
  assign wsel    = chan_word_e'(addr[3:2]);

  always_comb begin
    hit_ch   = 1'b0;
    hit_ctrl = 1'b0;
    ch_idx   = '0;
    if (aligned) begin
      if (slot == SW'(CTRL_SLOT)) begin
        hit_ctrl = (addr[3:2] == 2'b00);
      end else if (slot <= SW'(NUM_CH)) begin
        hit_ch = 1'b1;
        ch_idx = CHW'(slot_to_chan(int'(slot), CTRL_SLOT));
      end
    end
    miss = !(hit_ch || hit_ctrl);
  end

endmodule

// File: rtl/tmr_ctrl_seq.sv
`timescale 1ns/1ps
module tmr_ctrl_seq
  import tmr_dec_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int PULSE_FIRST = 4,
  localparam int CW         = NUM_CH * CTRL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CW-1:0]     wdata,
  output logic [CW-1:0]     ctrl_q,
  output logic              pulse_err,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] clk_ext_o,
  output logic [NUM_CH-1:0] irq_en_o,
  output logic [NUM_CH-1:0] pulse_o,
  output logic [NUM_CH-1:0] dis_stb_o,
  output logic [NUM_CH-1:0] ena_stb_o,
  output logic [NUM_CH-1:0] cfg_stb_o
);

  // events of the current write, one bit per channel
  logic [NUM_CH-1:0] stop_now;
  logic [NUM_CH-1:0] start_now;
  logic [NUM_CH-1:0] cfg_chg;
  logic [NUM_CH-1:0] bad_pulse;
  logic [NUM_CH-1:0] nxt_clk, nxt_irq, nxt_pulse;
  // enables waiting for the second cycle
  logic [NUM_CH-1:0] start_pend_q;
  logic [NUM_CH-1:0] en_q, clk_q, irq_q, pulse_q;
  logic [NUM_CH-1:0] dis_stb_q, ena_stb_q, cfg_stb_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam bit CAN_PULSE = (i >= PULSE_FIRST);
    logic [CTRL_BITS-1:0] old_f, new_f, diff_f;
    assign old_f  = ctrl_q[i*CTRL_BITS +: CTRL_BITS];
    assign new_f  = wdata[i*CTRL_BITS +: CTRL_BITS];
    assign diff_f = old_f ^ new_f;

    assign stop_now[i]  = wr &&  old_f[CB_RUN] && !new_f[CB_RUN];
    assign start_now[i] = wr && !old_f[CB_RUN] &&  new_f[CB_RUN];
    assign cfg_chg[i]   = wr && (diff_f[CB_EXTCLK] || diff_f[CB_IRQ] ||
                                 (CAN_PULSE && diff_f[CB_PULSE]));
    assign bad_pulse[i] = wr && !CAN_PULSE && diff_f[CB_PULSE];
    assign nxt_clk[i]   = new_f[CB_EXTCLK];
    assign nxt_irq[i]   = new_f[CB_IRQ];
    assign nxt_pulse[i] = CAN_PULSE && new_f[CB_PULSE];

    // R6
    en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_o[i]) |-> dis_stb_o[i]);
    // R6
    stop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis_stb_o[i] |-> !en_o[i]);
    // R7
    en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_o[i]) |-> ena_stb_o[i]);
    // R7
    start_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ena_stb_o[i] |-> $past(wr, 2) && !$past(wr && start_now[i]));
  end

  assign pulse_err = |bad_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q       <= '0;
      start_pend_q <= '0;
      en_q         <= '0;
      clk_q        <= '0;
      irq_q        <= '0;
      pulse_q      <= '0;
      dis_stb_q    <= '0;
      ena_stb_q    <= '0;
      cfg_stb_q    <= '0;
    end else begin
      // second cycle: pending enables land unless a newer write stops them
      en_q         <= (en_q | start_pend_q) & ~stop_now;
      ena_stb_q    <= start_pend_q & ~stop_now;
      start_pend_q <= start_now;
      // first cycle: stops and configuration together
      dis_stb_q    <= stop_now;
      cfg_stb_q    <= cfg_chg;
      if (wr) begin
        ctrl_q  <= wdata;
        clk_q   <= nxt_clk;
        irq_q   <= nxt_irq;
        pulse_q <= nxt_pulse;
      end
    end
  end

  assign en_o      = en_q;
  assign clk_ext_o = clk_q;
  assign irq_en_o  = irq_q;
  assign pulse_o   = pulse_q;
  assign dis_stb_o = dis_stb_q;
  assign ena_stb_o = ena_stb_q;
  assign cfg_stb_o = cfg_stb_q;

endmodule

// File: rtl/tmr_read_mux.sv
`timescale 1ns/1ps
module tmr_read_mux
  import tmr_dec_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DW     = 32,
  localparam int CHW   = $clog2(NUM_CH),
  localparam int CW    = NUM_CH * CTRL_BITS,
  localparam int RBW   = NUM_CH * WORDS_PER_CH * DW
) (
  input  logic           hit_ch,
  input  logic           hit_ctrl,
  input  logic [CHW-1:0] ch_idx,
  input  chan_word_e     wsel,
  input  logic [RBW-1:0] ch_rdata,
  input  logic [CW-1:0]  ctrl_q,
  output logic [DW-1:0]  rdata
);

  always_comb begin
    rdata = '0;
    if (hit_ch)
      rdata = ch_rdata[word_base(int'(ch_idx), int'(wsel), DW) +: DW];
    else if (hit_ctrl)
      rdata = DW'(ctrl_q);
  end

endmodule

// File: rtl/tmr_bank_decoder.sv
`timescale 1ns/1ps
module tmr_bank_decoder
  import tmr_dec_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int DW          = 32,
  parameter int AW          = 12,
  parameter int CTRL_SLOT   = 3,
  parameter int PULSE_FIRST = 4,
  localparam int CHW        = $clog2(NUM_CH),
  localparam int CW         = NUM_CH * CTRL_BITS,
  localparam int RBW        = NUM_CH * WORDS_PER_CH * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_err,
  output logic [NUM_CH-1:0] ch_wr_o,
  output logic [1:0]        ch_wr_sel_o,
  output logic [DW-1:0]     ch_wr_data_o,
  input  logic [RBW-1:0]    ch_rdata_i,
  output logic [NUM_CH-1:0] ch_en_o,
  output logic [NUM_CH-1:0] ch_clk_ext_o,
  output logic [NUM_CH-1:0] ch_irq_en_o,
  output logic [NUM_CH-1:0] ch_pulse_o,
  output logic [NUM_CH-1:0] ch_dis_stb_o,
  output logic [NUM_CH-1:0] ch_ena_stb_o,
  output logic [NUM_CH-1:0] ch_cfg_stb_o
);

  logic           hit_ch, hit_ctrl, miss;
  logic [CHW-1:0] ch_idx;
  chan_word_e     wsel;
  logic [CW-1:0]  ctrl_q;
  logic [DW-1:0]  rd_mux;
  logic           pulse_err;
  logic           ctrl_wr, chan_wr, rd_req;
  logic [NUM_CH-1:0] ch_wr_q;
  logic [1:0]     wr_sel_q;
  logic [DW-1:0]  wr_data_q, rdata_q;
  logic           err_q;

  tmr_addr_decode #(.AW(AW), .NUM_CH(NUM_CH), .CTRL_SLOT(CTRL_SLOT)) u_dec (
    .addr     (req_addr),
    .hit_ch   (hit_ch),
    .hit_ctrl (hit_ctrl),
    .miss     (miss),
    .ch_idx   (ch_idx),
    .wsel     (wsel)
  );

  assign ctrl_wr = req_valid && req_write && hit_ctrl;
  assign chan_wr = req_valid && req_write && hit_ch;
  assign rd_req  = req_valid && !req_write;

  tmr_ctrl_seq #(.NUM_CH(NUM_CH), .PULSE_FIRST(PULSE_FIRST)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (ctrl_wr),
    .wdata     (req_wdata[CW-1:0]),
    .ctrl_q    (ctrl_q),
    .pulse_err (pulse_err),
    .en_o      (ch_en_o),
    .clk_ext_o (ch_clk_ext_o),
    .irq_en_o  (ch_irq_en_o),
    .pulse_o   (ch_pulse_o),
    .dis_stb_o (ch_dis_stb_o),
    .ena_stb_o (ch_ena_stb_o),
    .cfg_stb_o (ch_cfg_stb_o)
  );

  tmr_read_mux #(.NUM_CH(NUM_CH), .DW(DW)) u_rmux (
    .hit_ch   (hit_ch),
    .hit_ctrl (hit_ctrl),
    .ch_idx   (ch_idx),
    .wsel     (wsel),
    .ch_rdata (ch_rdata_i),
    .ctrl_q   (ctrl_q),
    .rdata    (rd_mux)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_wr_q   <= '0;
      wr_sel_q  <= '0;
      wr_data_q <= '0;
      rdata_q   <= '0;
      err_q     <= 1'b0;
    end else begin
      ch_wr_q <= chan_wr ? (NUM_CH'(1) << ch_idx) : '0;
      if (chan_wr) begin
        wr_sel_q  <= wsel;
        wr_data_q <= req_wdata;
      end
      if (rd_req)
        rdata_q <= rd_mux;
      err_q <= req_valid && (miss || (ctrl_wr && pulse_err));
    end
  end

  assign ch_wr_o      = ch_wr_q;
  assign ch_wr_sel_o  = wr_sel_q;
  assign ch_wr_data_o = wr_data_q;
  assign rsp_rdata    = rdata_q;
  assign rsp_err      = err_q;

  // R2
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_wr_o));
  // R10
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && miss) |=> (ch_wr_o == '0) && rsp_err);
  // R10
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && miss) |=> (rsp_rdata == '0));
  // R9
  low_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && pulse_err) |=> rsp_err);

endmodule

// File: tb/tmr_bank_decoder_test.sv
`timescale 1ns/1ps
module tmr_bank_decoder_test;

  localparam int NCH = 8;
  localparam int DW  = 32;
  localparam int AW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rsp_rdata;
  logic rsp_err;
  logic [NCH-1:0] ch_wr_o;
  logic [1:0] ch_wr_sel_o;
  logic [DW-1:0] ch_wr_data_o;
  logic [NCH*4*DW-1:0] ch_rdata_i;
  logic [NCH-1:0] ch_en_o, ch_clk_ext_o, ch_irq_en_o, ch_pulse_o;
  logic [NCH-1:0] ch_dis_stb_o, ch_ena_stb_o, ch_cfg_stb_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_bank_decoder uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .ch_wr_o(ch_wr_o), .ch_wr_sel_o(ch_wr_sel_o),
    .ch_wr_data_o(ch_wr_data_o), .ch_rdata_i(ch_rdata_i), .ch_en_o(ch_en_o),
    .ch_clk_ext_o(ch_clk_ext_o), .ch_irq_en_o(ch_irq_en_o), .ch_pulse_o(ch_pulse_o),
    .ch_dis_stb_o(ch_dis_stb_o), .ch_ena_stb_o(ch_ena_stb_o), .ch_cfg_stb_o(ch_cfg_stb_o)
  );

  // value each channel presents for a word: tagged with channel and select
  function automatic logic [31:0] chan_val(int c, int w);
    return {8'h5A, 8'(c), 8'(w), 8'hC3};
  endfunction

  initial begin
    for (int c = 0; c < NCH; c++)
      for (int w = 0; w < 4; w++)
        ch_rdata_i[(c*4+w)*32 +: 32] = chan_val(c, w);
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one access; returns at the falling edge after the capturing edge
  task automatic access(bit wr, logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "en", 32'(ch_en_o), 0);
    chk("R1", "levels", 32'({ch_clk_ext_o, ch_irq_en_o, ch_pulse_o}), 0);
    chk("R1", "strobes", 32'({ch_wr_o, ch_dis_stb_o, ch_ena_stb_o, ch_cfg_stb_o}), 0);
    chk("R1", "err", 32'(rsp_err), 0);
    access(1'b0, 12'h030, 0);
    chk("R1", "ctrl readback", rsp_rdata, 0);
  endtask

  task automatic t_chan_write;
    access(1'b1, 12'h014, 32'hDEAD_0001);
    chk("R2", "wr ch1", 32'(ch_wr_o), 32'h02);
    chk("R2", "sel reload", 32'(ch_wr_sel_o), 1);
    chk("R2", "data", ch_wr_data_o, 32'hDEAD_0001);
    @(negedge clk);
    chk("R2", "strobe one cycle", 32'(ch_wr_o), 0);
    access(1'b1, 12'h048, 32'h0000_BEEF);
    chk("R2", "wr slot4 ch3", 32'(ch_wr_o), 32'h08);
    chk("R2", "sel matcha", 32'(ch_wr_sel_o), 2);
    access(1'b1, 12'h08C, 32'h1234_5678);
    chk("R2", "wr last ch7", 32'(ch_wr_o), 32'h80);
    chk("R2", "sel matchb", 32'(ch_wr_sel_o), 3);
    chk("R2", "data last", ch_wr_data_o, 32'h1234_5678);
    chk("R10", "no err on good write", 32'(rsp_err), 0);
  endtask

  task automatic t_chan_read;
    access(1'b0, 12'h000, 0);
    chk("R3", "ch0 count", rsp_rdata, chan_val(0, 0));
    access(1'b0, 12'h02C, 0);
    chk("R3", "ch2 matchb", rsp_rdata, chan_val(2, 3));
    access(1'b0, 12'h040, 0);
    chk("R3", "ch3 count", rsp_rdata, chan_val(3, 0));
    access(1'b0, 12'h084, 0);
    chk("R3", "ch7 reload", rsp_rdata, chan_val(7, 1));
    chk("R3", "no err", 32'(rsp_err), 0);
  endtask

  // ch0 run, ch1 ext clock, ch5 irq, ch6 pulse
  localparam logic [31:0] V1 = 32'h0840_0021;
  localparam logic [31:0] V2 = 32'h0840_0000;
  localparam logic [31:0] V3 = 32'h0840_0500;
  localparam logic [31:0] V5 = 32'h0840_0008;

  task automatic t_ctrl_enable;
    access(1'b1, 12'h030, V1);
    chk("R5", "ext clk", 32'(ch_clk_ext_o), 32'h02);
    chk("R5", "irq en", 32'(ch_irq_en_o), 32'h20);
    chk("R5", "pulse high ch", 32'(ch_pulse_o), 32'h40);
    chk("R8", "cfg strobes", 32'(ch_cfg_stb_o), 32'h62);
    chk("R7", "en not yet", 32'(ch_en_o), 0);
    chk("R7", "start not yet", 32'(ch_ena_stb_o), 0);
    @(negedge clk);
    chk("R7", "en second cycle", 32'(ch_en_o), 32'h01);
    chk("R7", "start strobe", 32'(ch_ena_stb_o), 32'h01);
    chk("R8", "cfg strobe gone", 32'(ch_cfg_stb_o), 0);
    @(negedge clk);
    chk("R7", "start one cycle", 32'(ch_ena_stb_o), 0);
    chk("R7", "en held", 32'(ch_en_o), 32'h01);
    access(1'b0, 12'h030, 0);
    chk("R4", "ctrl readback", rsp_rdata, V1);
  endtask

  task automatic t_ctrl_disable;
    access(1'b1, 12'h030, V2);
    chk("R6", "en off first cycle", 32'(ch_en_o), 0);
    chk("R6", "stop strobe", 32'(ch_dis_stb_o), 32'h01);
    chk("R6", "cfg same cycle", 32'(ch_clk_ext_o), 0);
    chk("R8", "cfg strobe ch1", 32'(ch_cfg_stb_o), 32'h02);
    @(negedge clk);
    chk("R6", "stop one cycle", 32'(ch_dis_stb_o), 0);
  endtask

  task automatic t_same_config;
    access(1'b1, 12'h030, V3);
    chk("R7", "irq ch2 first", 32'(ch_irq_en_o), 32'h24);
    chk("R7", "en ch2 waits", 32'(ch_en_o), 0);
    chk("R8", "cfg ch2", 32'(ch_cfg_stb_o), 32'h04);
    @(negedge clk);
    chk("R7", "en ch2 second", 32'(ch_en_o), 32'h04);
    chk("R7", "start ch2", 32'(ch_ena_stb_o), 32'h04);
    access(1'b1, 12'h030, V2);
    chk("R6", "en ch2 off", 32'(ch_en_o), 0);
    chk("R6", "irq ch2 off", 32'(ch_irq_en_o), 32'h20);
    chk("R6", "stop ch2", 32'(ch_dis_stb_o), 32'h04);
    chk("R8", "cfg ch2 off", 32'(ch_cfg_stb_o), 32'h04);
    access(1'b1, 12'h030, V2);
    chk("R8", "rewrite no cfg", 32'(ch_cfg_stb_o), 0);
    chk("R8", "rewrite no stop", 32'(ch_dis_stb_o), 0);
    chk("R8", "rewrite no err", 32'(rsp_err), 0);
    @(negedge clk);
    chk("R8", "rewrite no start", 32'(ch_ena_stb_o), 0);
  endtask

  task automatic t_low_pulse;
    access(1'b1, 12'h030, V5);
    chk("R9", "err raised", 32'(rsp_err), 1);
    chk("R9", "pulse unchanged", 32'(ch_pulse_o), 32'h40);
    chk("R9", "no cfg strobe", 32'(ch_cfg_stb_o), 0);
    @(negedge clk);
    chk("R11", "err one cycle", 32'(rsp_err), 0);
    access(1'b0, 12'h030, 0);
    chk("R9", "bit kept", rsp_rdata, V5);
    access(1'b1, 12'h030, V5);
    chk("R9", "unchanged no err", 32'(rsp_err), 0);
  endtask

  task automatic t_undecoded;
    access(1'b0, 12'h034, 0);
    chk("R10", "0x34 reads 0", rsp_rdata, 0);
    chk("R10", "0x34 err", 32'(rsp_err), 1);
    access(1'b0, 12'h084, 0);
    access(1'b0, 12'h03C, 0);
    chk("R10", "0x3C reads 0", rsp_rdata, 0);
    access(1'b0, 12'h090, 0);
    chk("R10", "past end err", 32'(rsp_err), 1);
    access(1'b0, 12'h082, 0);
    chk("R10", "misaligned err", 32'(rsp_err), 1);
    access(1'b1, 12'h090, 32'hFFFF_FFFF);
    chk("R10", "no strobe past end", 32'(ch_wr_o), 0);
    chk("R10", "write err", 32'(rsp_err), 1);
    access(1'b1, 12'h011, 32'hFFFF_FFFF);
    chk("R10", "no strobe misaligned", 32'(ch_wr_o), 0);
    access(1'b1, 12'h034, 32'hFFFF_FFFF);
    chk("R10", "no cfg from 0x34", 32'(ch_cfg_stb_o), 0);
    @(negedge clk);
    chk("R11", "err one cycle", 32'(rsp_err), 0);
    access(1'b0, 12'h030, 0);
    chk("R10", "ctrl untouched", rsp_rdata, V5);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chan_write();
    t_chan_read();
    t_ctrl_enable();
    t_ctrl_disable();
    t_same_config();
    t_low_pulse();
    t_undecoded();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule